// File: doc/BRIEF.md
# Dual-Unit Reconfigurable Datapath Tile

This block is a single tile of a reconfigurable datapath array. Three routed operands arrive on it, named A, B and C. The tile holds two units. The first is a function unit. The second is a transfer unit, which forwards data toward a row further down the array than the next one. A build-time position (row and column index) fixes the kind of arithmetic the function unit does, following a checkerboard pattern: tiles where the sum of row and column is even add or subtract, and tiles where it is odd multiply. Integer arithmetic stands in for floating point.

Each input of the function unit comes through a four-way selector. The selector picks one of the routed operands A, B or C, or the tile's own immediate register. The tile has four usage modes: function only, transfer only, function with transfer, and two transfers. Both results are registered, so each output appears exactly one clock after the inputs that produce it.

Configuration arrives one bit per clock. The bits collect in a shadow shift chain, and a commit pulse then copies the chain into the active configuration in a single step. The configuration holds the mode, the subtract control, both selector codes and the immediate value. The bit leaving the chain is brought out on a port so that tiles can be daisy-chained.

Top module: `rdp_tile`

## Requirements
- R1: While reset is low, both outputs are zero, and the shadow and active configuration are all zero. After reset, with no configuration committed, the tile is in function-only mode, adding with both selectors set to A, so `fu_out` becomes 2*A.
- R2: A clock with `cfg_en` high shifts the shadow chain one place toward bit 0 and loads `cfg_bit` into the top bit, CFG_W-1. The first bit sent therefore ends at bit 0 after CFG_W shifts. `cfg_out` always shows shadow bit 0.
- R3: The active configuration changes only on a clock with `cfg_commit` high. On that clock it takes the shadow value from before any shift made on the same clock. Shifting alone leaves the outputs' behaviour unchanged.
- R4: The configuration word holds these fields: mode in bits [1:0], subtract in bit 2, the first-operand selector in [4:3], the second-operand selector in [6:5], and the immediate value in [CTRL_W+DATA_W-1:7]. The selector codes are 0 for A, 1 for B, 2 for C and 3 for the immediate.
- R5: When (ROW_IDX+COL_IDX) is even, the function unit adds or subtracts. When it is odd, the unit multiplies and keeps the low DATA_W bits of the product.
- R6: On an add/subtract tile, a subtract bit of 1 gives first minus second modulo 2^DATA_W, and 0 gives their sum. On a multiply tile the subtract bit has no effect on the result.
- R7: Mode 0 (function only) puts the function result on `fu_out` and drives `tu_out` to zero.
- R8: Mode 1 (transfer only) puts C on `tu_out` and drives `fu_out` to zero.
- R9: Mode 2 (function with transfer) puts the function result on `fu_out` and C on `tu_out`.
- R10: Mode 3 (two transfers) puts A on `fu_out` and C on `tu_out`.
- R11: Each output reflects the inputs and active configuration of the previous clock edge, through exactly one register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_a | input | DATA_W | Routed operand A |
| in_b | input | DATA_W | Routed operand B |
| in_c | input | DATA_W | Routed operand C, the transfer source |
| cfg_en | input | 1 | Shift one configuration bit this clock |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_commit | input | 1 | Copy the shadow chain into the active configuration |
| cfg_out | output | 1 | Shadow chain bit 0, for daisy-chaining |
| fu_out | output | DATA_W | Function result, or A in two-transfer mode |
| tu_out | output | DATA_W | Transfer output (C) |

## Verification
The clocked assertions take two things for granted. The first is that reset is held low for at least one clock edge before use. The second is that a commit and a shift landing on the same edge are legal and follow the pre-shift rule in R3; the checker states this rule, so it is not excluded.

The stimulus changes every input only on the falling edge. It keeps `cfg_commit` low while the chain is shifting, so each loaded word commits whole. A second tile at an odd checkerboard position receives the same inputs, which brings the multiply variant under the same checks.

// File: rtl/rdp_tile_pkg.sv
package rdp_tile_pkg;

   typedef enum logic [1:0] {
      MODE_FU    = 2'd0,
      MODE_TU    = 2'd1,
      MODE_FU_TU = 2'd2,
      MODE_TU_TU = 2'd3
   } tile_mode_e;

   typedef enum logic [1:0] {
      SEL_A   = 2'd0,
      SEL_B   = 2'd1,
      SEL_C   = 2'd2,
      SEL_IMM = 2'd3
   } opnd_sel_e;

   // Packed control fields; first member is most significant.
   typedef struct packed {
      opnd_sel_e  sel_b;
      opnd_sel_e  sel_a;
      logic       sub;
      tile_mode_e mode;
   } tile_ctrl_t;

   localparam int CTRL_W = $bits(tile_ctrl_t);

endpackage

// File: rtl/rdp_cfg_chain.sv
module rdp_cfg_chain #(
   parameter int CFG_W = 71
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             shift_en,
   input  logic             shift_bit,
   input  logic             commit,
   output logic             chain_out,
   output logic [CFG_W-1:0] active
);

   generate
      if (CFG_W < 2) begin : g_bad_width
         $error("rdp_cfg_chain: CFG_W must be at least 2");
      end
   endgenerate

   logic [CFG_W-1:0] shadow;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shadow <= '0;
      end else if (shift_en) begin
         shadow <= {shift_bit, shadow[CFG_W-1:1]};
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= '0;
      end else if (commit) begin
         active <= shadow;
      end
   end

   assign chain_out = shadow[0];

   a_r2_shift_moves: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (shadow[CFG_W-2:0] == $past(shadow[CFG_W-1:1])) && (shadow[CFG_W-1] == $past(shift_bit)));

   a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> $stable(active));

   a_r3_commit_pre_shift: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> (active == $past(shadow)));

endmodule

// File: rtl/rdp_operand_mux.sv
module rdp_operand_mux
   import rdp_tile_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  opnd_sel_e         sel,
   input  logic [DATA_W-1:0] opnd_a,
   input  logic [DATA_W-1:0] opnd_b,
   input  logic [DATA_W-1:0] opnd_c,
   input  logic [DATA_W-1:0] imm,
   output logic [DATA_W-1:0] picked
);

   always_comb begin
      unique case (sel)
         SEL_A:   picked = opnd_a;
         SEL_B:   picked = opnd_b;
         SEL_C:   picked = opnd_c;
         SEL_IMM: picked = imm;
         default: picked = '0;
      endcase
   end

endmodule

// File: rtl/rdp_func_unit.sv
module rdp_func_unit #(
   parameter int DATA_W = 64,
   parameter bit IS_MUL = 1'b0
) (
   input  logic [DATA_W-1:0] lhs,
   input  logic [DATA_W-1:0] rhs,
   input  logic              sub,
   output logic [DATA_W-1:0] result
);

   generate
      if (IS_MUL) begin : g_mul
         logic unused_sub;
         assign unused_sub = sub;
         assign result     = lhs * rhs;
      end else begin : g_addsub
         assign result = sub ? (lhs - rhs) : (lhs + rhs);
      end
   endgenerate

endmodule

// File: rtl/rdp_tile.sv
module rdp_tile
   import rdp_tile_pkg::*;
#(
   parameter int DATA_W  = 64,
   parameter int ROW_IDX = 0,
   parameter int COL_IDX = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   input  logic [DATA_W-1:0] in_c,
   input  logic              cfg_en,
   input  logic              cfg_bit,
   input  logic              cfg_commit,
   output logic              cfg_out,
   output logic [DATA_W-1:0] fu_out,
   output logic [DATA_W-1:0] tu_out
);

   localparam int CFG_W  = CTRL_W + DATA_W;
   localparam bit IS_MUL = (((ROW_IDX + COL_IDX) % 2) == 1);

   generate
      if (DATA_W < 2) begin : g_bad_data
         $error("rdp_tile: DATA_W must be at least 2");
      end
      if (ROW_IDX < 0 || COL_IDX < 0) begin : g_bad_pos
         $error("rdp_tile: position indices must be non-negative");
      end
   endgenerate

   logic [CFG_W-1:0]  cfg_active;
   tile_ctrl_t        ctrl;
   logic [DATA_W-1:0] imm;
   logic [DATA_W-1:0] lhs, rhs, fu_res;
   logic [DATA_W-1:0] fu_next, tu_next;

   rdp_cfg_chain #(.CFG_W(CFG_W)) u_cfg (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (cfg_en),
      .shift_bit (cfg_bit),
      .commit    (cfg_commit),
      .chain_out (cfg_out),
      .active    (cfg_active)
   );

   assign ctrl = tile_ctrl_t'(cfg_active[CTRL_W-1:0]);
   assign imm  = cfg_active[CFG_W-1:CTRL_W];

   rdp_operand_mux #(.DATA_W(DATA_W)) u_mux_lhs (
      .sel    (ctrl.sel_a),
      .opnd_a (in_a),
      .opnd_b (in_b),
      .opnd_c (in_c),
      .imm    (imm),
      .picked (lhs)
   );

   rdp_operand_mux #(.DATA_W(DATA_W)) u_mux_rhs (
      .sel    (ctrl.sel_b),
      .opnd_a (in_a),
      .opnd_b (in_b),
      .opnd_c (in_c),
      .imm    (imm),
      .picked (rhs)
   );

   rdp_func_unit #(.DATA_W(DATA_W), .IS_MUL(IS_MUL)) u_fu (
      .lhs    (lhs),
      .rhs    (rhs),
      .sub    (ctrl.sub),
      .result (fu_res)
   );

   always_comb begin
      unique case (ctrl.mode)
         MODE_FU:    begin fu_next = fu_res; tu_next = '0;   end
         MODE_TU:    begin fu_next = '0;     tu_next = in_c; end
         MODE_FU_TU: begin fu_next = fu_res; tu_next = in_c; end
         MODE_TU_TU: begin fu_next = in_a;   tu_next = in_c; end
         default:    begin fu_next = '0;     tu_next = '0;   end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fu_out <= '0;
         tu_out <= '0;
      end else begin
         fu_out <= fu_next;
         tu_out <= tu_next;
      end
   end

   a_r7_fu_only_tu_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode == MODE_FU) |=> (tu_out == '0));

   a_r8_tu_only_fu_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode == MODE_TU) |=> (fu_out == '0));

   a_r10_dual_transfer_a: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode == MODE_TU_TU) |=> (fu_out == $past(in_a)));

   a_r11_transfer_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode != MODE_FU) |=> (tu_out == $past(in_c)));

   a_r9_fu_result_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl.mode == MODE_FU_TU) |=> (fu_out == $past(fu_res)));

endmodule

// File: tb/rdp_tile_bench.sv
module rdp_tile_bench;
   import rdp_tile_pkg::*;

   localparam int DATA_W = 64;
   localparam int CFG_W  = CTRL_W + DATA_W;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [DATA_W-1:0] in_a = '0, in_b = '0, in_c = '0;
   logic              cfg_en = 1'b0, cfg_bit = 1'b0, cfg_commit = 1'b0;
   logic              cfg_out_add, cfg_out_mul;
   logic [DATA_W-1:0] fu_add, tu_add, fu_mul, tu_mul;

   always #2 clk = ~clk;

   rdp_tile #(.DATA_W(DATA_W), .ROW_IDX(0), .COL_IDX(0)) u_rdp_tile (
      .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
      .cfg_en(cfg_en), .cfg_bit(cfg_bit), .cfg_commit(cfg_commit),
      .cfg_out(cfg_out_add), .fu_out(fu_add), .tu_out(tu_add)
   );

   rdp_tile #(.DATA_W(DATA_W), .ROW_IDX(2), .COL_IDX(1)) u_rdp_tile_mul (
      .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b), .in_c(in_c),
      .cfg_en(cfg_en), .cfg_bit(cfg_bit), .cfg_commit(cfg_commit),
      .cfg_out(cfg_out_mul), .fu_out(fu_mul), .tu_out(tu_mul)
   );

   int    checks = 0;
   int    failures = 0;
   string cur_tag = "R1";

   // Behavioural reference model
   logic [CFG_W-1:0]  m_shadow = '0;
   logic [CFG_W-1:0]  m_active = '0;
   logic [DATA_W-1:0] e_fu_add = '0, e_tu_add = '0, e_fu_mul = '0, e_tu_mul = '0;

   function automatic logic [DATA_W-1:0] pick(int code, logic [CFG_W-1:0] w);
      case (code)
         0: return in_a;
         1: return in_b;
         2: return in_c;
         default: return w[CFG_W-1:7];
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_shadow = '0; m_active = '0;
         e_fu_add = '0; e_tu_add = '0; e_fu_mul = '0; e_tu_mul = '0;
      end else begin
         int md; logic [DATA_W-1:0] x, y, r_add, r_mul;
         md = int'(m_active[1:0]);
         x = pick(int'(m_active[4:3]), m_active);
         y = pick(int'(m_active[6:5]), m_active);
         r_add = m_active[2] ? x - y : x + y;
         r_mul = x * y;
         e_fu_add = (md == 0 || md == 2) ? r_add : (md == 3 ? in_a : '0);
         e_fu_mul = (md == 0 || md == 2) ? r_mul : (md == 3 ? in_a : '0);
         e_tu_add = (md == 0) ? '0 : in_c;
         e_tu_mul = e_tu_add;
         if (cfg_commit) m_active = m_shadow;
         if (cfg_en) m_shadow = {cfg_bit, m_shadow[CFG_W-1:1]};
      end
   end

   task automatic check(string tag, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Compare on every clock, away from the active edge
   always @(negedge clk) begin
      check(cur_tag, "fu_out even tile", fu_add, e_fu_add);
      check(cur_tag, "tu_out even tile", tu_add, e_tu_add);
      check(cur_tag == "R6" ? "R6" : "R5", "fu_out odd tile", fu_mul, e_fu_mul);
      check(cur_tag, "tu_out odd tile", tu_mul, e_tu_mul);
      check("R2", "cfg_out", {{(DATA_W-1){1'b0}}, cfg_out_add}, {{(DATA_W-1){1'b0}}, m_shadow[0]});
   end

   task automatic drive_rand(int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_a = {$urandom, $urandom};
         in_b = {$urandom, $urandom};
         in_c = {$urandom, $urandom};
      end
   endtask

   task automatic drive_fixed(logic [DATA_W-1:0] a, logic [DATA_W-1:0] b, logic [DATA_W-1:0] c);
      @(negedge clk);
      in_a = a; in_b = b; in_c = c;
   endtask

   // Word layout per R4: mode[1:0], sub[2], sel_a[4:3], sel_b[6:5], immediate above
   task automatic load_cfg(int mode, bit sub, int sa, int sb, logic [DATA_W-1:0] imm);
      logic [CFG_W-1:0] w;
      w = {imm, 2'(sb), 2'(sa), sub, 2'(mode)};
      cur_tag = "R3";
      for (int i = 0; i < CFG_W; i++) begin
         @(negedge clk);
         cfg_en = 1'b1; cfg_bit = w[i];
         in_a = {$urandom, $urandom};
      end
      @(negedge clk);
      cfg_en = 1'b0; cfg_commit = 1'b1;
      @(negedge clk);
      cfg_commit = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      // R1: reset state and default configuration
      cur_tag = "R1";
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      drive_rand(4);
      drive_fixed(64'd5, 64'd9, 64'd7);
      // R7: function only, A op B
      load_cfg(0, 1'b0, 0, 1, 64'h0);
      cur_tag = "R7";
      drive_rand(6);
      // R5: wrap at the top of the range
      cur_tag = "R5";
      drive_fixed('1, 64'd1, 64'd3);
      drive_fixed(64'h8000_0000_0000_0001, 64'd2, 64'd0);
      drive_rand(4);
      // R6: subtract, including a borrow below zero
      load_cfg(0, 1'b1, 0, 1, 64'h0);
      cur_tag = "R6";
      drive_fixed(64'd3, 64'd10, 64'd0);
      drive_fixed(64'd10, 64'd3, 64'd0);
      drive_rand(4);
      // R4: immediate and C as operands
      load_cfg(2, 1'b1, 3, 2, 64'h0123_4567_89ab_cdef);
      cur_tag = "R4";
      drive_rand(4);
      load_cfg(0, 1'b0, 2, 3, 64'hffff_0000_ffff_0000);
      cur_tag = "R4";
      drive_rand(4);
      // R8: transfer only
      load_cfg(1, 1'b0, 0, 1, 64'h55);
      cur_tag = "R8";
      drive_rand(5);
      // R9: function with transfer
      load_cfg(2, 1'b0, 1, 2, 64'h0);
      cur_tag = "R9";
      drive_rand(5);
      // R10: two transfers
      load_cfg(3, 1'b1, 3, 3, 64'h77);
      cur_tag = "R10";
      drive_rand(5);
      // R11: back-to-back distinct inputs, one-stage latency
      load_cfg(2, 1'b1, 0, 1, 64'h0);
      cur_tag = "R11";
      drive_fixed(64'd100, 64'd1, 64'd11);
      drive_fixed(64'd200, 64'd2, 64'd22);
      drive_fixed(64'd300, 64'd3, 64'd33);
      drive_rand(5);
      // R1: reset again clears the configuration
      @(negedge clk);
      cur_tag = "R1";
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      drive_rand(3);
      @(negedge clk);
      @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule